// File: doc/BRIEF.md
# AXI4 Read Burst Splitter

This block turns one kernel read command, given as a start byte address and a total word count, into a series of AXI4 read address requests. Each request covers at most `MAX_BURST` beats, and none of them runs past a 4096-byte address boundary. A request that would cross a boundary is cut short exactly at the boundary, and the next request starts there. The returned read data, together with its response code, is placed in an internal FIFO and handed downstream on a plain valid/ready word stream in ascending address order. A one-cycle `done` pulse marks the delivery of the last word of the command.

Requests go out as soon as they are allowed, without waiting for the downstream consumer. Two limits hold them back. First, at most `MAX_OUTSTD` bursts may be waiting for their last beat. Second, a request is only issued when FIFO room is reserved for every one of its beats. The FIFO holds `MAX_OUTSTD * MAX_BURST` words, so the read channel is never back-pressured. The data width is a parameter between 8 and 512 bits.

Top module: `rd_burst_split`

## Requirements
- R1: After reset `cmd_ready` is 1, and `arvalid`, `out_valid` and `done` are 0. A command transfers on `cmd_valid && cmd_ready`. After a non-empty command is accepted, `cmd_ready` is 0 from the next cycle until its last word has been delivered.
- R2: Every burst carries 1 to `MAX_BURST` beats. `arlen` is the beat count minus one. `arburst` is 2'b01 (incrementing). `arsize` is log2(DATA_W/8), which is 2 for 32-bit data.
- R3: No burst crosses a 4096-byte boundary. Each burst length is the smallest of three values: `MAX_BURST`, the words still to request, and the words left before the next boundary. The first burst starts at `cmd_addr`, and each later one starts at the previous address plus beats × DATA_W/8.
- R4: The number of bursts accepted on the address channel whose `rlast` beat has not yet returned never exceeds `MAX_OUTSTD`. This limit is reached when the memory is slow.
- R5: `rready` is held at 1. A burst is only requested when FIFO room is reserved for all of its beats. With `out_ready` held low, exactly `MAX_OUTSTD*MAX_BURST` words' worth of bursts are requested, and then requests stop.
- R6: Address requests are raised without waiting on `out_ready` beyond the reservation rule. While `arvalid && !arready`, `arvalid`, `araddr` and `arlen` hold steady.
- R7: Output words appear in ascending address order with no gaps. Each word carries the `rresp` of its beat on `out_resp`.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of the command's last word.
- R9: A command with a word count of 0 is accepted but produces no address request and no `done`, and `cmd_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may transfer |
| cmd_addr | input | ADDR_W | Start byte address, beat aligned |
| cmd_words | input | CNT_W | Number of data words to read |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address accepted |
| araddr | output | ADDR_W | Burst start address |
| arlen | output | 8 | Beats in burst minus one |
| arsize | output | 3 | Bytes per beat, log2 encoded |
| arburst | output | 2 | Burst type, always incrementing |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data accepted, held at 1 |
| rdata | input | DATA_W | Read data beat |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last beat of a burst |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Output word |
| out_resp | output | 2 | Response code of the output word |
| done | output | 1 | Last word of the command delivered |

## Verification
A request becomes visible on `arvalid` one cycle after the command handshake. A read beat written into the FIFO shows on `out_valid` in the following cycle. `done` rises in the cycle right after the handshake of the final word. The bench decides each handshake at the falling edge, using outputs that come only from registers. The R8 check then expects `done` at exactly the next falling edge and nowhere else. Address requests and output words are compared against queues of independently computed bursts and words. The stall and slow-memory scenarios count requests after the pipeline has settled, so these checks do not depend on exact latencies.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int unsigned PAGE_BYTES  = 4096;
   localparam int unsigned AXI_LEN_CAP = 256;
   localparam logic [1:0]  BURST_INCR  = 2'b01;
endpackage

// File: rtl/rbs_frag.sv
module rbs_frag #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned MAX_BURST  = 16,
   parameter int unsigned BEAT_BYTES = 4,
   localparam int unsigned BEAT_W    = $clog2(MAX_BURST + 1),
   localparam int unsigned BSH       = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_words,
   input  logic              issue_ok,
   input  logic              ar_ready,
   output logic              busy,
   output logic              ar_valid,
   output logic [ADDR_W-1:0] ar_addr,
   output logic [BEAT_W-1:0] ar_beats
);
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remain;

   always_comb begin
      int unsigned room;
      int unsigned len;
      room = (rbs_pkg::PAGE_BYTES - 32'(cur_addr[11:0])) >> BSH;
      len  = MAX_BURST;
      if (room < len) len = room;
      if (32'(remain) < len) len = 32'(remain);
      ar_beats = len[BEAT_W-1:0];
   end

   assign ar_valid = busy && issue_ok;
   assign ar_addr  = cur_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
      end else if (start) begin
         busy     <= (start_words != '0);
         cur_addr <= start_addr;
         remain   <= start_words;
      end else if (ar_valid && ar_ready) begin
         cur_addr <= cur_addr + ADDR_W'(32'(ar_beats) << BSH);
         remain   <= remain - CNT_W'(ar_beats);
         if (remain == CNT_W'(ar_beats)) busy <= 1'b0;
      end
   end

   AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid |-> (ar_beats != '0 && 32'(ar_beats) <= MAX_BURST)); // R2
   AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid |-> (32'(ar_addr[11:0]) + (32'(ar_beats) << BSH) <= rbs_pkg::PAGE_BYTES)); // R3
   AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_beats)); // R6
endmodule

// File: rtl/rbs_track.sv
module rbs_track #(
   parameter int unsigned OUTSTD  = 16,
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned BEAT_W  = 5,
   localparam int unsigned BUR_W  = $clog2(OUTSTD + 1),
   localparam int unsigned RES_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BEAT_W-1:0] ar_beats,
   input  logic              ar_fire,
   input  logic              r_fire,
   input  logic              r_last,
   input  logic              out_fire,
   output logic              issue_ok
);
   logic [BUR_W-1:0] bursts;
   logic [RES_W-1:0] reserved;

   assign issue_ok = (32'(bursts) < OUTSTD) &&
                     (32'(reserved) + 32'(ar_beats) <= DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bursts   <= '0;
         reserved <= '0;
      end else begin
         case ({ar_fire, r_fire && r_last})
            2'b10:   bursts <= bursts + 1'b1;
            2'b01:   bursts <= bursts - 1'b1;
            default: bursts <= bursts;
         endcase
         reserved <= reserved + (ar_fire ? RES_W'(ar_beats) : '0) - RES_W'(out_fire);
      end
   end

   AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      32'(bursts) <= OUTSTD); // R4
   AST_DATA_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      r_fire |-> bursts != '0); // R4
   AST_RESERVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(reserved) <= DEPTH); // R5
endmodule

// File: rtl/rbs_fifo.sv
module rbs_fifo #(
   parameter int unsigned W     = 34,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] count;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nxt = (32'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
         assign rp_nxt = (32'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr) wp <= wp_nxt;
         if (rd) rp <= rp_nxt;
         count <= count + CW'(wr) - CW'(rd);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> 32'(count) < DEPTH); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !empty); // R7
endmodule

// File: rtl/rd_burst_split.sv
module rd_burst_split #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned MAX_BURST  = 16,
   parameter int unsigned MAX_OUTSTD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_words,
   output logic              arvalid,
   input  logic              arready,
   output logic [ADDR_W-1:0] araddr,
   output logic [7:0]        arlen,
   output logic [2:0]        arsize,
   output logic [1:0]        arburst,
   input  logic              rvalid,
   output logic              rready,
   input  logic [DATA_W-1:0] rdata,
   input  logic [1:0]        rresp,
   input  logic              rlast,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [1:0]        out_resp,
   output logic              done
);
   localparam int unsigned BEAT_BYTES = DATA_W / 8;
   localparam int unsigned FIFO_DEPTH = MAX_OUTSTD * MAX_BURST;
   localparam int unsigned BEAT_W     = $clog2(MAX_BURST + 1);
   localparam logic [2:0]  SIZE_CODE  = 3'($clog2(BEAT_BYTES));

   generate
      if (DATA_W < 8 || DATA_W > 512 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two from 8 to 512");
      end
      if (MAX_BURST < 1 || MAX_BURST > rbs_pkg::AXI_LEN_CAP) begin : g_bad_burst
         $error("MAX_BURST must be 1 to 256");
      end
      if (MAX_OUTSTD < 1 || FIFO_DEPTH < 2) begin : g_bad_outstd
         $error("MAX_OUTSTD*MAX_BURST must be at least 2");
      end
      if (ADDR_W < 12 || ADDR_W > 64 || CNT_W < 1 || CNT_W > 31) begin : g_bad_addr
         $error("ADDR_W must be 12..64 and CNT_W 1..31");
      end
   endgenerate

   logic              busy, issue_ok, cmd_fire, ar_fire, r_fire, out_fire, fifo_empty;
   logic [BEAT_W-1:0] ar_beats;
   logic [CNT_W-1:0]  left;
   logic [DATA_W+1:0] fifo_out;

   assign cmd_ready = !busy && (left == '0);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign ar_fire   = arvalid && arready;
   assign rready    = 1'b1;
   assign r_fire    = rvalid && rready;
   assign out_valid = !fifo_empty;
   assign out_fire  = out_valid && out_ready;
   assign arlen     = 8'(ar_beats - BEAT_W'(1));
   assign arsize    = SIZE_CODE;
   assign arburst   = rbs_pkg::BURST_INCR;
   assign out_data  = fifo_out[DATA_W-1:0];
   assign out_resp  = fifo_out[DATA_W+1:DATA_W];

   rbs_frag #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .BEAT_BYTES(BEAT_BYTES)) u_frag (
      .clk(clk), .rst_n(rst_n), .start(cmd_fire), .start_addr(cmd_addr),
      .start_words(cmd_words), .issue_ok(issue_ok), .ar_ready(arready),
      .busy(busy), .ar_valid(arvalid), .ar_addr(araddr), .ar_beats(ar_beats));

   rbs_track #(.OUTSTD(MAX_OUTSTD), .DEPTH(FIFO_DEPTH), .BEAT_W(BEAT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .ar_beats(ar_beats), .ar_fire(ar_fire),
      .r_fire(r_fire), .r_last(rlast), .out_fire(out_fire), .issue_ok(issue_ok));

   rbs_fifo #(.W(DATA_W + 2), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(r_fire), .wdata({rresp, rdata}),
      .rd(out_fire), .rdata(fifo_out), .empty(fifo_empty));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left <= '0;
         done <= 1'b0;
      end else begin
         done <= out_fire && (left == CNT_W'(1));
         if (cmd_fire)      left <= cmd_words;
         else if (out_fire) left <= left - 1'b1;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_IDLE_NO_AR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !arvalid); // R1
endmodule

// File: tb/test_rd_burst_split.sv
module test_rd_burst_split;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid, cmd_ready;
   logic [31:0] cmd_addr;
   logic [15:0] cmd_words;
   logic        arvalid, arready;
   logic [31:0] araddr;
   logic [7:0]  arlen;
   logic [2:0]  arsize;
   logic [1:0]  arburst;
   logic        rvalid, rready, rlast;
   logic [31:0] rdata;
   logic [1:0]  rresp;
   logic        out_valid, out_ready, done;
   logic [31:0] out_data;
   logic [1:0]  out_resp;

   always #5 clk = ~clk;

   rd_burst_split i_rd_burst_split (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_words(cmd_words), .arvalid(arvalid), .arready(arready),
      .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
      .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_resp(out_resp), .done(done));

   int tests = 0, fails = 0;
   logic [31:0] ar_exp_addr[$];
   logic [7:0]  ar_exp_len[$];
   logic [31:0] sb_data[$];
   logic [1:0]  sb_resp[$];
   bit          sb_last[$];
   logic [31:0] sl_addr[$];
   logic [7:0]  sl_len[$];
   int  sl_beat = 0, sl_gap = 0, r_delay = 0;
   int  outst = 0, max_out = 0, ar_cnt = 0, done_cnt = 0;
   bit  stall = 0, done_due = 0, hold_prev = 0, finished = 0;
   logic [31:0] addr_prev;

   function automatic logic [31:0] word_of(input logic [31:0] a);
      return (a * 32'h0001_0003) ^ 32'hC3A5_0000;
   endfunction
   function automatic logic [1:0] resp_of(input logic [31:0] a);
      return (a[5:2] == 4'd9) ? 2'b10 : 2'b00;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // slave, monitor and scoreboard, all decided at the falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_due) chk(done === 1'b1, "R8", "done after last word", done, 1);
         else if (done !== 1'b0) chk(0, "R8", "stray done", done, 0);
         if (done === 1'b1) done_cnt++;
         done_due = 0;

         if (sl_addr.size() > 0 && sl_gap == 0) begin
            rvalid = 1'b1;
            rdata  = word_of(sl_addr[0] + 32'(sl_beat * 4));
            rresp  = resp_of(sl_addr[0] + 32'(sl_beat * 4));
            rlast  = (sl_beat == int'(sl_len[0]));
            if (rlast) begin
               void'(sl_addr.pop_front());
               void'(sl_len.pop_front());
               sl_beat = 0;
               outst--;
               sl_gap = r_delay + int'($urandom % 3);
            end else sl_beat++;
         end else begin
            rvalid = 1'b0;
            rlast  = 1'b0;
            if (sl_gap > 0) sl_gap--;
         end
         if (rvalid && rready !== 1'b1) chk(0, "R5", "rready low", rready, 1);

         if (hold_prev)
            chk(arvalid === 1'b1 && araddr == addr_prev, "R6", "held request", araddr, addr_prev);
         arready = ($urandom % 10) < 7;
         hold_prev = arvalid && !arready;
         addr_prev = araddr;
         if (arvalid && arready) begin
            if (ar_exp_addr.size() == 0) chk(0, "R3", "unexpected request", araddr, 0);
            else begin
               chk(araddr == ar_exp_addr[0], "R3", "burst address", araddr, ar_exp_addr[0]);
               chk(arlen == ar_exp_len[0], "R2", "arlen", arlen, ar_exp_len[0]);
               void'(ar_exp_addr.pop_front());
               void'(ar_exp_len.pop_front());
            end
            chk(arburst == 2'b01 && arsize == 3'd2, "R2", "arburst/arsize",
                {arburst, arsize}, {2'b01, 3'd2});
            chk(32'(araddr[11:0]) + (32'(arlen) + 1) * 4 <= 4096, "R3", "page crossing",
                araddr, arlen);
            sl_addr.push_back(araddr);
            sl_len.push_back(arlen);
            outst++;
            ar_cnt++;
            if (outst > max_out) max_out = outst;
            chk(outst <= 16, "R4", "outstanding bursts", outst, 16);
         end

         out_ready = stall ? 1'b0 : (($urandom % 4) != 0);
         if (out_valid && out_ready) begin
            if (sb_data.size() == 0) chk(0, "R7", "unexpected word", out_data, 0);
            else begin
               chk(out_data == sb_data[0], "R7", "word data", out_data, sb_data[0]);
               chk(out_resp == sb_resp[0], "R7", "word resp", out_resp, sb_resp[0]);
               if (sb_last[0]) done_due = 1;
               void'(sb_data.pop_front());
               void'(sb_resp.pop_front());
               void'(sb_last.pop_front());
            end
         end
      end
   end

   task automatic run_cmd(input logic [31:0] a0, input int n);
      logic [31:0] a;
      int left;
      a = a0;
      left = n;
      while (left > 0) begin
         int b;
         b = 16;
         if (left < b) b = left;
         if ((4096 - int'(a % 4096)) / 4 < b) b = (4096 - int'(a % 4096)) / 4;
         ar_exp_addr.push_back(a);
         ar_exp_len.push_back(8'(b - 1));
         a = a + 32'(b * 4);
         left = left - b;
      end
      for (int i = 0; i < n; i++) begin
         sb_data.push_back(word_of(a0 + 32'(i * 4)));
         sb_resp.push_back(resp_of(a0 + 32'(i * 4)));
         sb_last.push_back(i == n - 1);
      end
      while (cmd_ready !== 1'b1) @(negedge clk);
      cmd_addr  = a0;
      cmd_words = 16'(n);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (n != 0) chk(cmd_ready === 1'b0, "R1", "cmd_ready while busy", cmd_ready, 0);
   endtask

   task automatic finish_cmd(input int prev_done);
      while (done_cnt == prev_done) @(negedge clk);
      chk(sb_data.size() == 0 && ar_exp_addr.size() == 0, "R7", "all words delivered",
          sb_data.size(), 0);
   endtask

   initial begin
      int d0;
      int a0;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_words = '0;
      arready = 1'b0; rvalid = 1'b0; rdata = '0; rresp = '0; rlast = 1'b0; out_ready = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready === 1'b1 && arvalid === 1'b0 && out_valid === 1'b0 && done === 1'b0,
          "R1", "reset state", {cmd_ready, arvalid, out_valid, done}, 4'b1000);

      d0 = done_cnt; run_cmd(32'h0000_0100, 1);  finish_cmd(d0);   // R7 single word
      d0 = done_cnt; run_cmd(32'h0000_0000, 37); finish_cmd(d0);   // R2 split 16/16/5
      d0 = done_cnt; run_cmd(32'h0000_0FF0, 40); finish_cmd(d0);   // R3 4/16/16/4
      d0 = done_cnt; run_cmd(32'h0000_1FC0, 20); finish_cmd(d0);   // R3 16/4
      d0 = done_cnt; run_cmd(32'h0000_2FFC, 3);  finish_cmd(d0);   // R3 1/2

      // R9 empty command
      d0 = done_cnt; a0 = ar_cnt;
      run_cmd(32'h0000_4000, 0);
      repeat (20) @(negedge clk);
      chk(ar_cnt == a0, "R9", "no request for empty command", ar_cnt, a0);
      chk(done_cnt == d0, "R9", "no done for empty command", done_cnt, d0);
      chk(cmd_ready === 1'b1, "R9", "ready after empty command", cmd_ready, 1);

      // R5 and R6: consumer stalled, requests fill the reservation then stop
      stall = 1; a0 = ar_cnt; d0 = done_cnt;
      run_cmd(32'h0000_8000, 400);
      repeat (200) @(negedge clk);
      chk(ar_cnt - a0 == 16, "R5", "bursts issued under stall", ar_cnt - a0, 16);
      chk(out_valid === 1'b1, "R6", "data waiting under stall", out_valid, 1);
      stall = 0;
      finish_cmd(d0);

      // R4: slow memory drives outstanding bursts to the limit
      r_delay = 40; max_out = 0; d0 = done_cnt;
      run_cmd(32'h0001_0000, 512);
      finish_cmd(d0);
      chk(max_out == 16, "R4", "peak outstanding bursts", max_out, 16);
      r_delay = 0;

      d0 = done_cnt; run_cmd(32'h0002_0F84, 70); finish_cmd(d0);  // R3 31 to the page edge
      repeat (3) @(negedge clk);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule